// File: doc/BRIEF.md
# Timer Compare Action Channel

This block is a single output-compare channel for a timer subsystem. Software programs an event time and a small control word. Each clock the channel looks at one of two free-running timer inputs. When the selected count moves onto the event time, the channel carries out one configured action: it sets, clears or toggles its output pin, or it sends a start strobe to an A/D converter. Each action also raises a match-pending flag.

A repeat bit in the control word chooses between two behaviours. With the bit set, the action fires on every later match. With it clear, the channel fires once and then stays quiet until the event-time register is written again. Only a write of the event time arms the channel. A write of the control word does not arm it.

Top module: `cmp_action_channel`

## Requirements
- R1: After reset, pin_out, adc_start and match_pend are 0, and the channel is disarmed until an event time is written.
- R2: A match is the selected timer value changing into equality with the event time: it becomes equal on a cycle after being unequal on the previous one. A timer that holds at the event time does not fire again.
- R3: The control bits [1:0] choose the pin action on a match: 00 leaves the pin unchanged, 01 drives it to 0, 10 drives it to 1, 11 inverts it.
- R4: When control bit [3] is 1, every match performs the action, with no further write needed.
- R5: When control bit [3] is 0, one action disarms the channel. Only a write to the event-time register arms it again. A control write alone does not.
- R6: adc_start is a one-clock pulse on each action whose code is 00, or on any action while control bit [2] is 1.
- R7: match_pend goes to 1 on each action and stays there until a pend_clr strobe. If an action and pend_clr fall in the same cycle, the action wins.
- R8: Control bit [4] selects the timer: 0 compares timer_a, 1 compares timer_b. The unselected timer has no effect.
- R9: All outputs are registered. The effect of a timer value appears one clock after it is presented. Register writes take effect at the clock edge, so the compare in the same cycle still uses the previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_a | input | TW | First free-running timer count |
| timer_b | input | TW | Second free-running timer count |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: {tsel, repeat, adc_en, action[1:0]} |
| evt_we | input | 1 | Event-time write strobe; arms the channel |
| evt_wdata | input | TW | Event time to compare against |
| pend_clr | input | 1 | Clears match_pend |
| pin_out | output | 1 | Compare output pin |
| adc_start | output | 1 | One-clock A/D start pulse |
| match_pend | output | 1 | Match-pending flag |

## Verification
The bench builds the channel with TW = 8. With this width, a wrap of the timer from 255 to 0 can be driven directly, so an event time of 0 is reached by a wrap and not only by counting up. The bench also checks one-shot and repeating operation over several passes, holds the timer at the event time, and writes the control word without writing the event time. A match on the unselected timer must have no effect. The action and pend_clr strobes are also made to coincide.

// File: rtl/cmp_action_channel.sv
module cmp_action_channel #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  input  logic          ctl_we,
  input  logic [4:0]    ctl_wdata,
  input  logic          evt_we,
  input  logic [TW-1:0] evt_wdata,
  input  logic          pend_clr,
  output logic          pin_out,
  output logic          adc_start,
  output logic          match_pend
);

  localparam logic [1:0] ACT_ADC = 2'b00;
  localparam logic [1:0] ACT_CLR = 2'b01;
  localparam logic [1:0] ACT_SET = 2'b10;
  localparam logic [1:0] ACT_TGL = 2'b11;

  logic [4:0]    ctl_q;
  logic [TW-1:0] evt_q;
  logic [TW-1:0] prev_q;
  logic          armed_q;

  wire [1:0]    act    = ctl_q[1:0];
  wire          adc_en = ctl_q[2];
  wire          repeat_en = ctl_q[3];
  wire [TW-1:0] tsel_v = ctl_q[4] ? timer_b : timer_a;
  wire          hit    = (tsel_v == evt_q) && (tsel_v != prev_q);
  wire          fire   = armed_q && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      evt_q   <= '0;
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= tsel_v;
      if (ctl_we) ctl_q <= ctl_wdata;
      if (evt_we) evt_q <= evt_wdata;
      if (evt_we) armed_q <= 1'b1;
      else if (fire && !repeat_en) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out    <= 1'b0;
      adc_start  <= 1'b0;
      match_pend <= 1'b0;
    end else begin
      adc_start  <= fire && (act == ACT_ADC || adc_en);
      match_pend <= fire || (match_pend && !pend_clr);
      if (fire) begin
        case (act)
          ACT_CLR: pin_out <= 1'b0;
          ACT_SET: pin_out <= 1'b1;
          ACT_TGL: pin_out <= ~pin_out;
          default: pin_out <= pin_out;
        endcase
      end
    end
  end

  AST_SET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    fire && act == ACT_SET |=> pin_out);  // R3
  AST_CLR_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    fire && act == ACT_CLR |=> !pin_out);  // R3
  AST_TOGGLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    fire && act == ACT_TGL |=> pin_out != $past(pin_out));  // R3
  AST_PEND_ON_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> match_pend);  // R7
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !repeat_en && !evt_we |=> !armed_q);  // R5
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> $stable(pin_out) && !adc_start);  // R5
  AST_ADC_IMPLIES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> match_pend);  // R6

endmodule

// File: tb/tb_cmp_action_channel.sv
module tb_cmp_action_channel;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] timer_a = 0, timer_b = 0, evt_wdata = 0;
  logic ctl_we = 0, evt_we = 0, pend_clr = 0;
  logic [4:0] ctl_wdata = 0;
  logic pin_out, adc_start, match_pend;

  always #5 clk = ~clk;

  cmp_action_channel #(.TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .timer_a(timer_a), .timer_b(timer_b),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .evt_we(evt_we),
    .evt_wdata(evt_wdata), .pend_clr(pend_clr), .pin_out(pin_out),
    .adc_start(adc_start), .match_pend(match_pend));

  typedef struct {
    logic  pin;
    logic  adc;
    logic  pend;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [4:0]    m_ctl = 0;
  logic [TW-1:0] m_evt = 0, m_prev = 0;
  logic          m_armed = 0, m_pin = 0, m_pend = 0;

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pin_out !== e.pin || adc_start !== e.adc || match_pend !== e.pend) begin
        errors++;
        $display("FAIL %s: pin/adc/pend actual %b%b%b expected %b%b%b",
                 e.tag, pin_out, adc_start, match_pend, e.pin, e.adc, e.pend);
      end
    end
  end

  task automatic step(input logic [TW-1:0] a, input logic [TW-1:0] b,
                      input logic cw, input logic [4:0] cd,
                      input logic ew, input logic [TW-1:0] ed,
                      input logic pc, input string tag);
    logic [TW-1:0] s;
    logic fire, adc;
    exp_t e;
    @(negedge clk);
    timer_a = a; timer_b = b; ctl_we = cw; ctl_wdata = cd;
    evt_we = ew; evt_wdata = ed; pend_clr = pc;
    s    = m_ctl[4] ? b : a;
    fire = m_armed && s == m_evt && s != m_prev;
    adc  = fire && (m_ctl[1:0] == 2'b00 || m_ctl[2]);
    if (fire) case (m_ctl[1:0])
      2'b01: m_pin = 0;
      2'b10: m_pin = 1;
      2'b11: m_pin = ~m_pin;
      default: ;
    endcase
    m_pend = fire || (m_pend && !pc);
    if (ew) m_armed = 1; else if (fire && !m_ctl[3]) m_armed = 0;
    m_prev = s;
    if (cw) m_ctl = cd;
    if (ew) m_evt = ed;
    e.pin = m_pin; e.adc = adc; e.pend = m_pend; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input logic [TW-1:0] a, input logic [TW-1:0] b, input string tag);
    step(a, b, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic sweep(input logic [TW-1:0] from, input int n, input string tag);
    for (int i = 0; i < n; i++) tick(from + TW'(i), 8'h40, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (pin_out !== 0 || adc_start !== 0 || match_pend !== 0) begin
      errors++;
      $display("FAIL R1: reset outputs actual %b%b%b expected 000", pin_out, adc_start, match_pend);
    end
    tick(8'd100, 8'h40, "R1 disarmed at event time 0/100");
    tick(8'd0, 8'h40, "R1 disarmed no fire at 0");
    // set action, one-shot, timer_a
    step(8'd90, 8'h40, 1, 5'b00010, 1, 8'd100, 0, "R9 writes");
    sweep(8'd97, 4, "R3 set pin / R9 latency");
    repeat (4) tick(8'd100, 8'h40, "R2 hold at match no refire");
    step(8'd101, 8'h40, 0, 0, 0, 0, 1, "R7 pend clear");
    sweep(8'd98, 4, "R5 one-shot no second fire");
    // control write only does not re-arm
    step(8'd50, 8'h40, 1, 5'b00001, 0, 0, 0, "R5 ctl write");
    sweep(8'd98, 4, "R5 ctl write does not re-arm");
    step(8'd50, 8'h40, 0, 0, 1, 8'd100, 0, "R5 evt write re-arms");
    sweep(8'd98, 4, "R3 clear pin");
    // toggle with repeat
    step(8'd50, 8'h40, 1, 5'b01011, 1, 8'd20, 1, "R4 setup");
    for (int p = 0; p < 3; p++) sweep(8'd18, 4, "R4 repeat toggle each pass");
    // wrap to event time 0
    step(8'd250, 8'h40, 0, 0, 1, 8'd0, 0, "R2 wrap setup");
    sweep(8'd253, 5, "R2 wrap into 0");
    // ADC only action
    step(8'd50, 8'h40, 1, 5'b01000, 1, 8'd60, 1, "R6 setup");
    sweep(8'd58, 4, "R6 adc-only pulse pin unchanged");
    sweep(8'd58, 4, "R6 adc repeat");
    // set with adc_en, pend clear coincident with action
    step(8'd50, 8'h40, 1, 5'b00110, 1, 8'd70, 0, "R6 setup2");
    tick(8'd68, 8'h40, "R6");
    tick(8'd69, 8'h40, "R6");
    step(8'd70, 8'h40, 0, 0, 0, 0, 1, "R7 action wins over clear");
    tick(8'd71, 8'h40, "R6 adc_en with set");
    // timer_b selection
    step(8'd50, 8'd10, 1, 5'b11011, 1, 8'd30, 1, "R8 setup");
    sweep(8'd28, 4, "R8 unselected timer_a ignored");
    for (int i = 0; i < 4; i++) tick(8'd5, 8'd28 + 8'(i), "R8 timer_b match toggles");
    step(8'd5, 8'd40, 0, 0, 0, 0, 1, "R7 clear");
    tick(8'd5, 8'd41, "R7 stays clear");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule